// File: doc/BRIEF.md
# Two-array TLB maintenance engine

This block holds two translation arrays and runs the maintenance commands that system software issues against them. Array 0 is set-associative: the page number of an address picks a set, and the entry's way is chosen within that set. Array 1 is small and fully associative, and each of its entries can cover a large page. A caller drives a command pulse together with its operands. The block returns a one-cycle `done` strobe and holds a result register set that describes one entry.

There are four commands. A search walks the addressed set of array 0 and then all of array 1, one entry per cycle, and stops at the first hit. On a hit it loads the result set from that entry. On a miss it builds a default result from the default inputs and the search context, and it advances a round-robin victim counter. A write stores one entry from the write operands. The write is refused when the requested page size is not allowed in the target array. Invalidate-by-address and invalidate-by-process-ID clear valid bits. They never clear an entry that carries the protect flag.

Top module: `tlbm_ctrl`

## Requirements
- R1: After reset every entry is invalid, the victim counter is 0, and `done`, `err` and all result outputs are 0. The first search after reset misses.
- R2: A search with address A hits an entry only if all four of these hold: the entry is valid, its process ID equals `ctx_pid`, its space bit equals `ctx_space`, and its page number equals A[31:12] with the low 2*size bits ignored (page = 4 KiB * 4^size). In array 0 only set A[15:12] is examined. A hit loads `res_*` from the entry, with real page bits [31:12] on `res_rpn_lo` and the bits above 31 on `res_rpn_hi`.
- R3: The search order is array 0 ways 0 to 3 first, then array 1 entries 0 to 7. The first hit wins. `res_arr` gives the array (0 or 1) and `res_way` gives the way or entry number.
- R4: On a miss the results are as follows. `res_arr`, `res_size` and `res_attr` come from `dflt_arr`, `dflt_size` and `dflt_attr`. `res_space` and `res_pid` come from the search context. `res_valid`, `res_prot`, `res_epn` and the real page are 0.
- R5: On a miss, `res_way` takes the victim counter. The counter then steps by one modulo 4, and `res_next` shows the new value. On a hit, `res_next` shows the counter, which does not change.
- R6: A search whose `ctx_space` differs from the entry's space bit misses.
- R7: Invalidate-by-address with `op_addr[2]`=1 clears every unprotected entry of one array: array 1 when `op_addr[3]`=1, array 0 otherwise. The other array is untouched.
- R8: Invalidate-by-address with `op_addr[2]`=0 targets array 1 when `op_addr[3]`=1 and array 0 otherwise; in array 0 it examines only set `op_addr[15:12]`. Within the target it clears only unprotected entries whose page number matches `op_addr[31:12]`, compared under each entry's own size mask.
- R9: An entry stored with its protect flag set survives every invalidate command.
- R10: Invalidate-by-PID clears, in both arrays, every unprotected entry whose process ID equals `ctx_pid`.
- R11: A write with `wr_valid`=1 and a size outside the target array's allowed set is refused. The refusal raises `err` with `done` and leaves the entry unchanged. Array 0 allows size 0 only; array 1 allows sizes 0 to 5. An invalid write is never refused.
- R12: Array 0 has no protection support, so a write there stores the protect flag as 0. Array 1 stores it as given. A write to array 0 lands in set `wr_epn[3:0]`, way `wr_sel[1:0]`; a write to array 1 lands in entry `wr_sel`.
- R13: Every accepted command produces exactly one `done` pulse, one cycle wide. Write and invalidate commands leave the result outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_search | input | 1 | Search pulse |
| cmd_write | input | 1 | Write-entry pulse |
| cmd_inv_addr | input | 1 | Invalidate-by-address pulse |
| cmd_inv_pid | input | 1 | Invalidate-by-PID pulse |
| op_addr | input | 32 | Address operand for search and invalidate |
| ctx_pid | input | 8 | Process ID used by search and invalidate-by-PID |
| ctx_space | input | 1 | Address-space bit used by search |
| dflt_arr | input | 1 | Array number reported on a miss |
| dflt_size | input | 4 | Size code reported on a miss |
| dflt_attr | input | 5 | Attribute bits reported on a miss |
| wr_arr | input | 1 | Target array of a write |
| wr_sel | input | 3 | Way (array 0) or entry (array 1) of a write |
| wr_valid | input | 1 | Valid flag to store |
| wr_prot | input | 1 | Protect flag to store |
| wr_space | input | 1 | Space bit to store |
| wr_pid | input | 8 | Process ID to store |
| wr_size | input | 4 | Size code to store |
| wr_epn | input | 20 | Virtual page number to store |
| wr_attr | input | 5 | Attribute bits to store |
| wr_rpn | input | 24 | Real page number to store |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Write refused, valid with done |
| res_arr | output | 1 | Result array number |
| res_way | output | 3 | Result way or entry |
| res_next | output | 2 | Suggested next victim way |
| res_valid | output | 1 | Result valid flag |
| res_prot | output | 1 | Result protect flag |
| res_space | output | 1 | Result space bit |
| res_pid | output | 8 | Result process ID |
| res_size | output | 4 | Result size code |
| res_epn | output | 20 | Result virtual page number |
| res_attr | output | 5 | Result attribute bits |
| res_rpn_lo | output | 20 | Real address bits 31:12 |
| res_rpn_hi | output | 4 | Real address bits 35:32 |

## Verification
The hardest case to reach from the ports is a protected large page in array 1 that sits in the path of an invalidation. The entry must match the address under its size mask, and it must also be the only thing that stops the clear. The stimulus places such a page next to unprotected small pages with the same process ID and nearby page numbers. It then runs each kind of invalidate against it: selective, whole-array and by-PID. After each one, a search whose address only the masked compare can match shows whether the protected page survived and whether its unprotected neighbours are gone.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int PAGE_SH = 12;
  localparam int EPN_W   = 32 - PAGE_SH;
  localparam int PID_W   = 8;
  localparam int SIZE_W  = 4;
  localparam int ATTR_W  = 5;
  localparam int RPN_W   = 24;
  localparam int RA_LO_W = 32 - PAGE_SH;

  typedef struct packed {
    logic              valid;
    logic              prot;
    logic              space;
    logic [PID_W-1:0]  pid;
    logic [SIZE_W-1:0] size;
    logic [EPN_W-1:0]  epn;
    logic [ATTR_W-1:0] attr;
    logic [RPN_W-1:0]  rpn;
  } tlbm_ent_t;

  typedef enum logic [1:0] {OP_SRCH, OP_INV_SEL, OP_INV_ALL, OP_INV_PID} tlbm_op_t;
endpackage

// File: rtl/tlbm_match.sv
module tlbm_match
  import tlbm_pkg::*;
(
  input  tlbm_ent_t        ent,
  input  logic [EPN_W-1:0] page,
  input  logic [PID_W-1:0] pid,
  input  logic             space,
  output logic             page_eq,
  output logic             pid_eq,
  output logic             space_eq
);
  logic [EPN_W-1:0] keep;

  // size code s ignores the low 2*s page bits (4 KiB * 4^s pages)
  always_comb begin
    keep     = {EPN_W{1'b1}} << (2 * ent.size);
    page_eq  = ((ent.epn ^ page) & keep) == '0;
    pid_eq   = ent.pid == pid;
    space_eq = ent.space == space;
  end
endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
  parameter int WAYS = 4,
  localparam int W   = $clog2(WAYS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q, q_d;

  always_comb begin
    nxt = (q == W'(WAYS - 1)) ? '0 : q + 1'b1;
    q_d = adv ? nxt : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign cur = q;
endmodule

// File: rtl/tlbm_seq.sv
module tlbm_seq #(
  parameter int IDX_W      = 7,
  parameter int JUMP_FIRST = 64,
  parameter int JUMP_LAST  = 71
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  input  logic             cont,
  input  logic             stop,
  output logic             busy,
  output logic [IDX_W-1:0] cur,
  output logic             fin
);
  logic             busy_q, busy_d, cont_q, cont_d, at_end;
  logic [IDX_W-1:0] cur_q, cur_d, last_q, last_d;

  always_comb begin
    at_end = cur_q == last_q;
    fin    = busy_q && (stop || (at_end && !cont_q));
    busy_d = busy_q;
    cur_d  = cur_q;
    last_d = last_q;
    cont_d = cont_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cur_d  = first;
      last_d = last;
      cont_d = cont;
    end else if (busy_q) begin
      if (fin) begin
        busy_d = 1'b0;
      end else if (at_end) begin
        cur_d  = IDX_W'(JUMP_FIRST);
        last_d = IDX_W'(JUMP_LAST);
        cont_d = 1'b0;
      end else begin
        cur_d = cur_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      cont_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      last_q <= last_d;
      cont_q <= cont_d;
    end
  end

  assign busy = busy_q;
  assign cur  = cur_q;

  // R3: the scan never runs past the end of its segment
  p_cursor_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cur_q <= last_q);
endmodule

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int SETS0 = 16,
  parameter int WAYS0 = 4,
  parameter int ENT1  = 8,
  parameter logic [(1<<SIZE_W)-1:0] SIZES0 = 16'h0001,
  parameter logic [(1<<SIZE_W)-1:0] SIZES1 = 16'h003F,
  parameter bit PROT0 = 1'b0,
  parameter bit PROT1 = 1'b1,
  localparam int SET_W = $clog2(SETS0),
  localparam int WAY_W = $clog2(WAYS0),
  localparam int E1_W  = $clog2(ENT1),
  localparam int SEL_W = (WAY_W > E1_W) ? WAY_W : E1_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_search,
  input  logic                     cmd_write,
  input  logic                     cmd_inv_addr,
  input  logic                     cmd_inv_pid,
  input  logic [31:0]              op_addr,
  input  logic [PID_W-1:0]         ctx_pid,
  input  logic                     ctx_space,
  input  logic                     dflt_arr,
  input  logic [SIZE_W-1:0]        dflt_size,
  input  logic [ATTR_W-1:0]        dflt_attr,
  input  logic                     wr_arr,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic                     wr_valid,
  input  logic                     wr_prot,
  input  logic                     wr_space,
  input  logic [PID_W-1:0]         wr_pid,
  input  logic [SIZE_W-1:0]        wr_size,
  input  logic [EPN_W-1:0]         wr_epn,
  input  logic [ATTR_W-1:0]        wr_attr,
  input  logic [RPN_W-1:0]         wr_rpn,
  output logic                     done,
  output logic                     err,
  output logic                     res_arr,
  output logic [SEL_W-1:0]         res_way,
  output logic [WAY_W-1:0]         res_next,
  output logic                     res_valid,
  output logic                     res_prot,
  output logic                     res_space,
  output logic [PID_W-1:0]         res_pid,
  output logic [SIZE_W-1:0]        res_size,
  output logic [EPN_W-1:0]         res_epn,
  output logic [ATTR_W-1:0]        res_attr,
  output logic [RA_LO_W-1:0]       res_rpn_lo,
  output logic [RPN_W-RA_LO_W-1:0] res_rpn_hi
);
  localparam int NENT0 = SETS0 * WAYS0;
  localparam int NENT  = NENT0 + ENT1;
  localparam int IDX_W = $clog2(NENT);

  tlbm_ent_t        ent_q [NENT];
  tlbm_ent_t        ent_d [NENT];
  tlbm_ent_t        cur_ent, res_q, res_d, wr_ent;
  tlbm_op_t         op_q, op_d;
  logic [EPN_W-1:0] pg_q;
  logic [PID_W-1:0] pid_q;
  logic             sp_q;
  logic             busy, fin, start_scan, cont, hit, kill, srch_fin, miss;
  logic             page_eq, pid_eq, space_eq;
  logic             wr_go, reject, prot_ok;
  logic [IDX_W-1:0] cur, first, last, base, wr_idx;
  logic [SET_W-1:0] set_in;
  logic [WAY_W-1:0] vic_cur, vic_nxt, res_next_q, res_next_d;
  logic [SEL_W-1:0] res_way_q, res_way_d;
  logic             res_arr_q, res_arr_d, done_q, err_q;
  logic             unused_bits;

  assign unused_bits = ^{op_addr[11:4], op_addr[1:0]};

  // ---- command decode: scan window per command ----
  assign set_in     = op_addr[PAGE_SH +: SET_W];
  assign base       = IDX_W'({set_in, {WAY_W{1'b0}}});
  assign start_scan = !busy && (cmd_search || cmd_inv_addr || cmd_inv_pid);

  always_comb begin
    first = '0;
    last  = IDX_W'(NENT - 1);
    cont  = 1'b0;
    op_d  = op_q;
    if (cmd_search) begin
      op_d  = OP_SRCH;
      first = base;
      last  = base + IDX_W'(WAYS0 - 1);
      cont  = 1'b1;
    end else if (cmd_inv_addr) begin
      op_d = op_addr[2] ? OP_INV_ALL : OP_INV_SEL;
      if (op_addr[3]) begin
        first = IDX_W'(NENT0);
        last  = IDX_W'(NENT - 1);
      end else if (op_addr[2]) begin
        first = '0;
        last  = IDX_W'(NENT0 - 1);
      end else begin
        first = base;
        last  = base + IDX_W'(WAYS0 - 1);
      end
    end else if (cmd_inv_pid) begin
      op_d = OP_INV_PID;
    end
  end

  tlbm_seq #(.IDX_W(IDX_W), .JUMP_FIRST(NENT0), .JUMP_LAST(NENT - 1)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_scan), .first(first), .last(last),
    .cont(cont), .stop(hit), .busy(busy), .cur(cur), .fin(fin));

  assign cur_ent = ent_q[cur];

  tlbm_match u_match (
    .ent(cur_ent), .page(pg_q), .pid(pid_q), .space(sp_q),
    .page_eq(page_eq), .pid_eq(pid_eq), .space_eq(space_eq));

  assign hit  = busy && op_q == OP_SRCH && cur_ent.valid && page_eq && pid_eq && space_eq;
  assign kill = busy && !cur_ent.prot &&
                (op_q == OP_INV_ALL || (op_q == OP_INV_SEL && page_eq) ||
                 (op_q == OP_INV_PID && pid_eq));
  assign srch_fin = fin && op_q == OP_SRCH;
  assign miss     = srch_fin && !hit;

  tlbm_victim #(.WAYS(WAYS0)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(miss), .cur(vic_cur), .nxt(vic_nxt));

  // ---- write path ----
  assign wr_go   = !busy && cmd_write;
  assign reject  = wr_valid && !(wr_arr ? SIZES1[wr_size] : SIZES0[wr_size]);
  assign prot_ok = wr_arr ? PROT1 : PROT0;
  assign wr_idx  = wr_arr ? IDX_W'(NENT0) + IDX_W'(wr_sel[E1_W-1:0])
                          : IDX_W'({wr_epn[SET_W-1:0], wr_sel[WAY_W-1:0]});

  always_comb begin
    wr_ent = '{valid: wr_valid, prot: wr_prot && prot_ok, space: wr_space, pid: wr_pid,
               size: wr_size, epn: wr_epn, attr: wr_attr, rpn: wr_rpn};
    ent_d = ent_q;
    if (kill) ent_d[cur].valid = 1'b0;
    if (wr_go && !reject) ent_d[wr_idx] = wr_ent;
  end

  // ---- result set ----
  always_comb begin
    if (hit) begin
      res_d      = cur_ent;
      res_arr_d  = cur >= IDX_W'(NENT0);
      res_way_d  = res_arr_d ? SEL_W'(cur - IDX_W'(NENT0)) : SEL_W'(cur[WAY_W-1:0]);
      res_next_d = vic_cur;
    end else begin
      res_d      = '{valid: 1'b0, prot: 1'b0, space: sp_q, pid: pid_q, size: dflt_size,
                     epn: '0, attr: dflt_attr, rpn: '0};
      res_arr_d  = dflt_arr;
      res_way_d  = SEL_W'(vic_cur);
      res_next_d = vic_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= '0;
      op_q       <= OP_SRCH;
      pg_q       <= '0;
      pid_q      <= '0;
      sp_q       <= 1'b0;
      res_q      <= '0;
      res_arr_q  <= 1'b0;
      res_way_q  <= '0;
      res_next_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      ent_q  <= ent_d;
      done_q <= fin || wr_go;
      err_q  <= wr_go && reject;
      if (start_scan) begin
        op_q  <= op_d;
        pg_q  <= op_addr[31:PAGE_SH];
        pid_q <= ctx_pid;
        sp_q  <= ctx_space;
      end
      if (srch_fin) begin
        res_q      <= res_d;
        res_arr_q  <= res_arr_d;
        res_way_q  <= res_way_d;
        res_next_q <= res_next_d;
      end
    end
  end

  assign done       = done_q;
  assign err        = err_q;
  assign res_arr    = res_arr_q;
  assign res_way    = res_way_q;
  assign res_next   = res_next_q;
  assign res_valid  = res_q.valid;
  assign res_prot   = res_q.prot;
  assign res_space  = res_q.space;
  assign res_pid    = res_q.pid;
  assign res_size   = res_q.size;
  assign res_epn    = res_q.epn;
  assign res_attr   = res_q.attr;
  assign res_rpn_lo = res_q.rpn[RA_LO_W-1:0];
  assign res_rpn_hi = res_q.rpn[RPN_W-1:RA_LO_W];

  // R13: at most one command pulse per cycle
  p_cmd_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_search, cmd_write, cmd_inv_addr, cmd_inv_pid}));

  // R11: a refusal is only ever reported for a write, with its strobe
  p_err_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && $past(cmd_write));

  // R5: the victim counter moves only together with a loaded miss result
  p_miss_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vic_cur) |-> done && !res_valid && (res_next == vic_cur));

  // R9: a protected valid entry visited by an invalidate scan stays valid
  p_prot_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != OP_SRCH && cur_ent.valid && cur_ent.prot) |=> ent_q[$past(cur)].valid);
endmodule

// File: tb/tlbm_ctrl_test.sv
module tlbm_ctrl_test;
  import tlbm_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 71;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_search, cmd_write, cmd_inv_addr, cmd_inv_pid;
  logic [31:0] op_addr;
  logic [7:0]  ctx_pid;
  logic        ctx_space;
  logic        dflt_arr;
  logic [3:0]  dflt_size;
  logic [4:0]  dflt_attr;
  logic        wr_arr;
  logic [2:0]  wr_sel;
  logic        wr_valid, wr_prot, wr_space;
  logic [7:0]  wr_pid;
  logic [3:0]  wr_size;
  logic [19:0] wr_epn;
  logic [4:0]  wr_attr;
  logic [23:0] wr_rpn;
  logic        done, err, res_arr, res_valid, res_prot, res_space;
  logic [2:0]  res_way;
  logic [1:0]  res_next;
  logic [7:0]  res_pid;
  logic [3:0]  res_size;
  logic [19:0] res_epn;
  logic [4:0]  res_attr;
  logic [19:0] res_rpn_lo;
  logic [3:0]  res_rpn_hi;

  tlbm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_search(cmd_search), .cmd_write(cmd_write),
    .cmd_inv_addr(cmd_inv_addr), .cmd_inv_pid(cmd_inv_pid), .op_addr(op_addr),
    .ctx_pid(ctx_pid), .ctx_space(ctx_space), .dflt_arr(dflt_arr), .dflt_size(dflt_size),
    .dflt_attr(dflt_attr), .wr_arr(wr_arr), .wr_sel(wr_sel), .wr_valid(wr_valid),
    .wr_prot(wr_prot), .wr_space(wr_space), .wr_pid(wr_pid), .wr_size(wr_size),
    .wr_epn(wr_epn), .wr_attr(wr_attr), .wr_rpn(wr_rpn), .done(done), .err(err),
    .res_arr(res_arr), .res_way(res_way), .res_next(res_next), .res_valid(res_valid),
    .res_prot(res_prot), .res_space(res_space), .res_pid(res_pid), .res_size(res_size),
    .res_epn(res_epn), .res_attr(res_attr), .res_rpn_lo(res_rpn_lo), .res_rpn_hi(res_rpn_hi));

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { logic [VW-1:0] v; string tag; } item_t;
  item_t sb[$];
  item_t it;
  int checks = 0, fails = 0, vict = 0;
  logic [VW-1:0] last_v = '0;
  logic [VW-1:0] act;

  function automatic logic [VW-1:0] pk(bit e, bit a, logic [2:0] w, logic [1:0] n, bit v,
      bit p, bit s, logic [7:0] pid, logic [3:0] sz, logic [19:0] epn, logic [4:0] at,
      logic [23:0] rpn);
    return {e, a, w, n, v, p, s, pid, sz, epn, at, rpn[23:20], rpn[19:0]};
  endfunction

  assign act = {err, res_arr, res_way, res_next, res_valid, res_prot, res_space, res_pid,
                res_size, res_epn, res_attr, res_rpn_hi, res_rpn_lo};

  task automatic chk(bit ok, string tag, logic [VW-1:0] a, logic [VW-1:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pops one expected item per done strobe
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (sb.size() == 0) chk(1'b0, "R13 done without a command", act, '0);
      else begin
        it = sb.pop_front();
        chk(act === it.v, it.tag, act, it.v);
      end
    end
  end

  task automatic fire(int k);
    @(negedge clk);
    cmd_search   = (k == 0);
    cmd_write    = (k == 1);
    cmd_inv_addr = (k == 2);
    cmd_inv_pid  = (k == 3);
    @(negedge clk);
    cmd_search = 0; cmd_write = 0; cmd_inv_addr = 0; cmd_inv_pid = 0;
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R13 done lasts one cycle", {70'd0, done}, '0);
  endtask

  task automatic push(logic [VW-1:0] v, string tag);
    item_t x;
    x.v = v; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic srch_miss(logic [19:0] epn, logic [7:0] pid, bit sp, string tag);
    logic [VW-1:0] e;
    e = pk(0, dflt_arr, 3'(vict), 2'((vict + 1) % 4), 0, 0, sp, pid, dflt_size, '0, dflt_attr, '0);
    vict = (vict + 1) % 4;
    last_v = e;
    push(e, tag);
    op_addr = {epn, 12'h000}; ctx_pid = pid; ctx_space = sp;
    fire(0);
  endtask

  task automatic srch_hit(logic [19:0] a_epn, logic [7:0] pid, bit sp, bit a, logic [2:0] w,
      bit p, logic [3:0] sz, logic [19:0] epn, logic [4:0] at, logic [23:0] rpn, string tag);
    logic [VW-1:0] e;
    e = pk(0, a, w, 2'(vict), 1, p, sp, pid, sz, epn, at, rpn);
    last_v = e;
    push(e, tag);
    op_addr = {a_epn, 12'h000}; ctx_pid = pid; ctx_space = sp;
    fire(0);
  endtask

  task automatic wr(bit a, logic [2:0] sel, logic [19:0] epn, bit v, bit p, logic [7:0] pid,
      logic [3:0] sz, logic [4:0] at, logic [23:0] rpn, bit rej, string tag);
    logic [VW-1:0] e;
    e = last_v; e[VW-1] = rej;
    push(e, tag);
    wr_arr = a; wr_sel = sel; wr_epn = epn; wr_valid = v; wr_prot = p; wr_space = 0;
    wr_pid = pid; wr_size = sz; wr_attr = at; wr_rpn = rpn;
    fire(1);
  endtask

  task automatic inv_addr(logic [31:0] addr, string tag);
    push(last_v, tag);
    op_addr = addr;
    fire(2);
  endtask

  task automatic inv_pid(logic [7:0] pid, string tag);
    push(last_v, tag);
    ctx_pid = pid;
    fire(3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    rst_n = 0;
    cmd_search = 0; cmd_write = 0; cmd_inv_addr = 0; cmd_inv_pid = 0;
    op_addr = '0; ctx_pid = '0; ctx_space = 0;
    dflt_arr = 1; dflt_size = 4'd2; dflt_attr = 5'h0A;
    wr_arr = 0; wr_sel = '0; wr_valid = 0; wr_prot = 0; wr_space = 0; wr_pid = '0;
    wr_size = '0; wr_epn = '0; wr_attr = '0; wr_rpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(act === '0, "R1 reset result outputs", act, '0);
    chk(done === 1'b0, "R1 reset done low", {70'd0, done}, '0);

    srch_miss(20'h12345, 8'd3, 0, "R1 R4 R5 first search misses");
    wr(0, 3'd2, 20'h12345, 1, 1, 8'd3, 4'd0, 5'h11, 24'hABCDE1, 0, "R12 R13 write a0");
    srch_hit(20'h12345, 8'd3, 0, 0, 3'd2, 0, 4'd0, 20'h12345, 5'h11, 24'hABCDE1, "R2 R12 hit a0 prot dropped");
    srch_miss(20'h12345, 8'd3, 1, "R6 space mismatch misses");
    srch_miss(20'h12345, 8'd4, 0, "R2 pid mismatch misses");

    wr(1, 3'd5, 20'h40000, 1, 1, 8'd7, 4'd2, 5'h03, 24'h123456, 0, "R12 write a1 large protected");
    wr(1, 3'd1, 20'h40000, 1, 0, 8'd7, 4'd0, 5'h04, 24'h000111, 0, "R12 write a1 small");
    wr(1, 3'd2, 20'h40002, 1, 0, 8'd9, 4'd0, 5'h06, 24'h000222, 0, "R12 write a1 small pid9");
    srch_hit(20'h40003, 8'd7, 0, 1, 3'd5, 1, 4'd2, 20'h40000, 5'h03, 24'h123456, "R3 masked large page hit");
    srch_hit(20'h40000, 8'd7, 0, 1, 3'd1, 0, 4'd0, 20'h40000, 5'h04, 24'h000111, "R3 lower entry wins");

    wr(0, 3'd2, 20'h12345, 1, 0, 8'd3, 4'd1, 5'h1F, 24'hFFFFFF, 1, "R11 refuse a0 size1");
    srch_hit(20'h12345, 8'd3, 0, 0, 3'd2, 0, 4'd0, 20'h12345, 5'h11, 24'hABCDE1, "R11 entry unchanged");
    wr(1, 3'd3, 20'h60000, 1, 0, 8'd1, 4'd6, 5'h01, 24'h000001, 1, "R11 refuse a1 size6");
    srch_miss(20'h60000, 8'd1, 0, "R11 refused entry absent");
    wr(1, 3'd4, 20'h70000, 0, 0, 8'd1, 4'd9, 5'h01, 24'h000001, 0, "R11 invalid write accepted");

    inv_addr({20'h40002, 12'h008}, "R8 R13 selective a1");
    srch_miss(20'h40002, 8'd9, 0, "R8 matching entry cleared");
    srch_hit(20'h40003, 8'd7, 0, 1, 3'd5, 1, 4'd2, 20'h40000, 5'h03, 24'h123456, "R9 protected survives selective");
    srch_hit(20'h40000, 8'd7, 0, 1, 3'd1, 0, 4'd0, 20'h40000, 5'h04, 24'h000111, "R8 other page kept");

    wr(0, 3'd0, 20'h40000, 1, 0, 8'd7, 4'd0, 5'h07, 24'h777777, 0, "R12 write a0 set0");
    srch_hit(20'h40000, 8'd7, 0, 0, 3'd0, 0, 4'd0, 20'h40000, 5'h07, 24'h777777, "R3 array0 first");

    inv_addr(32'h0000_0004, "R7 clear all a0");
    srch_hit(20'h40000, 8'd7, 0, 1, 3'd1, 0, 4'd0, 20'h40000, 5'h04, 24'h000111, "R7 a1 untouched");
    srch_miss(20'h12345, 8'd3, 0, "R7 a0 entry cleared");

    wr(0, 3'd1, 20'h00031, 1, 0, 8'd8, 4'd0, 5'h08, 24'h000031, 0, "R12 write a0 pid8");
    wr(0, 3'd3, 20'h00031, 1, 0, 8'd7, 4'd0, 5'h09, 24'h000032, 0, "R12 write a0 pid7");
    inv_pid(8'd7, "R10 clear pid7");
    srch_hit(20'h40000, 8'd7, 0, 1, 3'd5, 1, 4'd2, 20'h40000, 5'h03, 24'h123456, "R10 R9 a1 pid7 cleared, protected kept");
    srch_miss(20'h00031, 8'd7, 0, "R10 a0 pid7 cleared");
    srch_hit(20'h00031, 8'd8, 0, 0, 3'd1, 0, 4'd0, 20'h00031, 5'h08, 24'h000031, "R10 other pid kept");

    wr(1, 3'd0, 20'h00050, 1, 0, 8'd2, 4'd0, 5'h02, 24'h000050, 0, "R12 write a1 pid2");
    inv_addr(32'h0000_000C, "R7 clear all a1");
    srch_miss(20'h00050, 8'd2, 0, "R7 a1 entry cleared");
    srch_hit(20'h40003, 8'd7, 0, 1, 3'd5, 1, 4'd2, 20'h40000, 5'h03, 24'h123456, "R9 protected survives clear all");
    srch_hit(20'h00031, 8'd8, 0, 0, 3'd1, 0, 4'd0, 20'h00031, 5'h08, 24'h000031, "R7 a0 untouched");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R13 every command completed", VW'(sb.size()), '0);
    finish_run();
  end
endmodule